// File: doc/BRIEF.md
# UART baud tick generator

This block produces the oversampling tick that paces a UART's shift logic. The tick can come from either of two sources. One is a private 16-bit down-counter that runs on the block clock. The other is an overflow pulse from an external timer, which can be passed through as it is or halved.

A select input chooses the source. When the timer path is chosen, a rate-double input decides whether every overflow produces a tick or only every second one. When the private counter is chosen, the timer input has no effect, so the timer is free for other work.

Software loads the counter's divisor one byte at a time. The high byte is only staged when it is written. The whole 16-bit value takes effect when the low byte is written, and the counter restarts from the new value on that same write.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is 0 and the committed divisor is 0. With `src_sel`=1, no tick appears until a nonzero divisor is committed.
- R2: A write to the high byte alone (`div_hi_we`=1, `div_lo_we`=0) does not change the period or phase of the counter ticks.
- R3: A low-byte write commits the divisor D = {staged high byte, `div_lo_data`} and restarts the count. With `src_sel`=1, the first tick is visible after the (D+1)th rising edge following the write edge, and later ticks follow every D+1 cycles.
- R4: Each tick from the counter path is high for exactly one clock cycle.
- R5: A committed divisor of 0 produces no ticks on the counter path.
- R6: With `src_sel`=0 and `dbl_rate`=1, every cycle with `tmr_ovf`=1 gives `tick`=1 in the following cycle.
- R7: With `src_sel`=0 and `dbl_rate`=0, overflow pulses are halved by a toggle that reset clears. The first pulse after reset gives no tick, the second gives one, and the pattern repeats in that alternation.
- R8: With `src_sel`=1, `tmr_ovf` is ignored: it neither produces a tick nor advances the halving toggle.
- R9: With `src_sel`=0, the counter path produces no ticks at `tick`.
- R10: A low-byte write that lands in the cycle in which the count reaches zero suppresses that tick. The count restarts from the newly written value.
- R11: When the high and low bytes are written in the same cycle, the committed divisor uses the incoming high byte, not the staged one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also clocks the divisor counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_hi_we | input | 1 | Stage `div_hi_data` as the divisor high byte |
| div_hi_data | input | 8 | Divisor high byte |
| div_lo_we | input | 1 | Commit divisor using `div_lo_data` as the low byte |
| div_lo_data | input | 8 | Divisor low byte |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| src_sel | input | 1 | 0 selects the timer path, 1 selects the divisor counter |
| dbl_rate | input | 1 | Timer path: 1 passes every overflow, 0 passes every second |
| tick | output | 1 | Registered single-cycle baud tick |

## Verification
Two events can fall in the same cycle: a low-byte commit, and the counter reaching zero and reloading. To provoke this, the bench loads a divisor of 3 and counts three sampled cycles. It then issues a second low-byte write timed to land exactly on the zero cycle. The test passes only if the expected tick is absent and the next tick appears four cycles later, counted from the new write rather than from the old phase. A second same-cycle case writes the high and low bytes together, and the resulting tick period shows which high byte was committed.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  localparam int unsigned BYTE_W_DEF    = 8;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef enum logic {
    SRC_TIMER  = 1'b0,
    SRC_DIVGEN = 1'b1
  } tick_src_e;

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = baud_tick_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned BYTE_W = baud_tick_pkg::BYTE_W_DEF,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] hi_data,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] lo_data,
  output logic [DIV_W-1:0]  div_q,
  output logic              load,
  output logic [DIV_W-1:0]  load_val
);

  logic [BYTE_W-1:0] hi_stage_q, hi_stage_d;
  logic              hi_stage_en;
  logic [DIV_W-1:0]  div_d;
  logic              div_en;
  logic [BYTE_W-1:0] hi_eff;

  // incoming high byte wins over the staged one on a joint write
  always_comb begin
    hi_eff      = hi_we ? hi_data : hi_stage_q;
    hi_stage_en = hi_we;
    hi_stage_d  = hi_data;
    div_en      = lo_we;
    div_d       = {hi_eff, lo_data};
    load        = lo_we;
    load_val    = div_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hi_stage_q <= '0;
    end else if (hi_stage_en) begin
      hi_stage_q <= hi_stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end

  // R2
  hi_only_stable_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (hi_we && !lo_we) |=> $stable(div_q));

  // R3
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    lo_we |=> (div_q[BYTE_W-1:0] == $past(lo_data)));

  // R11
  joint_write_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (lo_we && hi_we) |=> (div_q[DIV_W-1:BYTE_W] == $past(hi_data)));

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int unsigned DIV_W = 2 * baud_tick_pkg::BYTE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_q,
  output logic             pulse
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_zero;
  logic             div_live;

  always_comb begin
    at_zero  = (cnt_q == '0);
    div_live = (div_q != '0);
    cnt_en   = 1'b0;
    cnt_d    = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (!at_zero) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end else if (div_live) begin
      cnt_en = 1'b1;
      cnt_d  = div_q;
    end
    pulse = at_zero && div_live && !load;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pulse |=> !pulse);

  // R3
  restart_value_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    load |=> (cnt_q == $past(load_val)));

  // R5
  zero_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!div_live && !load) |=> (cnt_q == '0));

  // R10
  reload_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pulse |=> (cnt_q == $past(div_q)));

endmodule

// File: rtl/baud_tmr_halver.sv
module baud_tmr_halver (
  input  logic clk,
  input  logic rst_ns,
  input  logic active,
  input  logic ovf,
  input  logic dbl,
  output logic pulse
);

  logic tgl_q, tgl_d;
  logic tgl_en;

  always_comb begin
    tgl_en = active && ovf && !dbl;
    tgl_d  = ~tgl_q;
    pulse  = active && ovf && (dbl || tgl_q);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tgl_q <= 1'b0;
    end else if (tgl_en) begin
      tgl_q <= tgl_d;
    end
  end

  // R8
  idle_toggle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !active |=> $stable(tgl_q));

  // R7
  first_half_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && ovf && !dbl && !tgl_q) |=> tgl_q);

  // R7
  second_half_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (pulse && !dbl) |=> !tgl_q);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned BYTE_W     = BYTE_W_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  localparam int unsigned DIV_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_hi_we,
  input  logic [BYTE_W-1:0] div_hi_data,
  input  logic              div_lo_we,
  input  logic [BYTE_W-1:0] div_lo_data,
  input  logic              tmr_ovf,
  input  logic              src_sel,
  input  logic              dbl_rate,
  output logic              tick
);

  logic             rst_ns;
  logic [DIV_W-1:0] div_q;
  logic             load;
  logic [DIV_W-1:0] load_val;
  logic             gen_pulse;
  logic             tmr_pulse;
  logic             tmr_active;
  tick_src_e        src;
  logic             tick_q, tick_d;

  baud_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  baud_div_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .hi_we    (div_hi_we),
    .hi_data  (div_hi_data),
    .lo_we    (div_lo_we),
    .lo_data  (div_lo_data),
    .div_q    (div_q),
    .load     (load),
    .load_val (load_val)
  );

  baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .load     (load),
    .load_val (load_val),
    .div_q    (div_q),
    .pulse    (gen_pulse)
  );

  baud_tmr_halver u_half (
    .clk    (clk),
    .rst_ns (rst_ns),
    .active (tmr_active),
    .ovf    (tmr_ovf),
    .dbl    (dbl_rate),
    .pulse  (tmr_pulse)
  );

  always_comb begin
    src        = tick_src_e'(src_sel);
    tmr_active = (src == SRC_TIMER);
    tick_d     = (src == SRC_DIVGEN) ? gen_pulse : tmr_pulse;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick = tick_q;

  // R8
  gen_path_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    src_sel |=> (tick == $past(gen_pulse)));

  // R9
  tmr_path_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !src_sel |=> (tick == $past(tmr_pulse)));

  // R6
  dbl_pass_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!src_sel && dbl_rate && tmr_ovf) |=> tick);

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  logic       clk;
  logic       rst_n;
  logic       div_hi_we, div_lo_we;
  logic [7:0] div_hi_data, div_lo_data;
  logic       tmr_ovf, src_sel, dbl_rate;
  logic       tick;
  int         checks;
  int         errors;

  // {src_sel, dbl_rate, tmr_ovf, expected tick next cycle}
  localparam logic [3:0] VEC [12] = '{
    4'b0111,  // R6 pass
    4'b0100,  // R6 no pulse
    4'b0111,  // R6 pass
    4'b0010,  // R7 first pulse swallowed
    4'b0011,  // R7 second pulse passes
    4'b0000,  // R7 idle
    4'b0010,  // R7 toggle to 1
    4'b1010,  // R8 ignored
    4'b1010,  // R8 ignored
    4'b0011,  // R8 toggle held, passes now
    4'b0111,  // R6 pass
    4'b0010   // R7 swallowed
  };

  baud_tick_gen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_hi_we   (div_hi_we),
    .div_hi_data (div_hi_data),
    .div_lo_we   (div_lo_we),
    .div_lo_data (div_lo_data),
    .tmr_ovf     (tmr_ovf),
    .src_sel     (src_sel),
    .dbl_rate    (dbl_rate),
    .tick        (tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tick=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_hi(input logic [7:0] v);
    div_hi_data = v;
    div_hi_we   = 1'b1;
    @(negedge clk);
    div_hi_we   = 1'b0;
  endtask

  task automatic write_lo(input logic [7:0] v);
    div_lo_data = v;
    div_lo_we   = 1'b1;
    @(negedge clk);
    div_lo_we   = 1'b0;
  endtask

  task automatic expect_ticks(input int n, input int first, input int period, input string tag);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(tick, (period > 0) && (k >= first) && (((k - first) % period) == 0), tag);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    div_hi_we = 1'b0;
    div_lo_we = 1'b0;
    tmr_ovf   = 1'b0;
    repeat (3) @(negedge clk);
    check(tick, 1'b0, "R1 tick in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles=200000 expected run to end earlier");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks      = 0;
    errors      = 0;
    div_hi_data = 8'h00;
    div_lo_data = 8'h00;
    src_sel     = 1'b1;
    dbl_rate    = 1'b0;
    do_reset();

    // R1: divisor zero after reset, no ticks
    expect_ticks(20, 0, 0, "R1 idle after reset");

    // R6 R7 R8 table walk
    for (int i = 0; i < 12; i++) begin
      {src_sel, dbl_rate, tmr_ovf} = VEC[i][3:1];
      @(negedge clk);
      check(tick, VEC[i][0], $sformatf("R6/R7/R8 vector %0d", i));
    end
    tmr_ovf = 1'b0;

    // R3 R4: divisor 3 -> period 4
    src_sel = 1'b1;
    write_hi(8'h00);
    write_lo(8'h03);
    expect_ticks(12, 4, 4, "R3/R4 divisor 3");

    // R2: high byte alone keeps phase
    write_hi(8'h01);
    expect_ticks(12, 3, 4, "R2 staged high byte");

    // R3: commit 0x0100 -> period 257
    write_lo(8'h00);
    expect_ticks(260, 257, 257, "R3 divisor 256");

    // R11: joint write uses incoming high byte
    write_hi(8'h05);
    div_hi_data = 8'h00;
    div_hi_we   = 1'b1;
    write_lo(8'h02);
    div_hi_we   = 1'b0;
    expect_ticks(9, 3, 3, "R11 joint write");

    // R10: write lands on the zero cycle
    write_lo(8'h03);
    expect_ticks(3, 0, 0, "R10 before zero");
    write_lo(8'h03);
    check(tick, 1'b0, "R10 suppressed tick");
    expect_ticks(8, 4, 4, "R10 restart");

    // R9: counter ignored on timer path
    src_sel = 1'b0;
    tmr_ovf = 1'b0;
    expect_ticks(20, 0, 0, "R9 counter masked");

    // R5: zero divisor
    src_sel = 1'b1;
    write_lo(8'h00);
    expect_ticks(30, 0, 0, "R5 zero divisor");

    // R1: reset clears divisor
    write_lo(8'h03);
    do_reset();
    src_sel = 1'b1;
    expect_ticks(20, 0, 0, "R1 divisor cleared");

    // R7: reset clears the toggle
    src_sel  = 1'b0;
    dbl_rate = 1'b0;
    tmr_ovf  = 1'b1;
    @(negedge clk);
    check(tick, 1'b0, "R7 first pulse after reset");
    @(negedge clk);
    check(tick, 1'b1, "R7 second pulse after reset");
    tmr_ovf = 1'b0;
    @(negedge clk);
    check(tick, 1'b0, "R7 no pulse");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule